// File: doc/BRIEF.md
# Segmented Data Address Generator

This block produces the physical data-RAM address for a small 8-bit controller core. Each access takes its 8-bit offset from one of four places: an address field carried in the instruction, one of two indirect pointer registers, or the stack pointer. A segment register widens the reach of the lower half of the offset space. Offsets below 80 hex are placed in the segment that the segment register selects. Offsets from 80 hex upward always land in segment 0, so registers and common data stay visible whatever segment is active.

Both indirect pointers can step up or down by one after the access they address. The stack pointer starts at 6F hex and grows toward lower addresses. A push writes at the current pointer and then steps down. A pop steps up first and reads at the new value. Software can load all four registers through a register-write port. Only segments 0 to 3 hold RAM. An access that would fall into a higher segment raises an out-of-range flag, and its write strobe is suppressed.

The address, the enable, the write strobe and the flag are all registered. They appear on the clock edge that ends the request cycle. The register values shown at the outputs are updated on that same edge.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst` is high, on each clock the pointers B and X and the segment register clear to 0, the stack pointer loads 6F hex, and `ram_en`, `ram_we`, `seg_oor` and `ram_addr` clear to 0.
- R2: A direct access (`acc_mode` 00 or 11) uses `dir_addr` as the offset. An offset of 00–7F hex yields `ram_addr` = {segment, offset}. An offset of 80–FF hex yields {00, offset}. Results show one clock after the request.
- R3: An access with `acc_mode` 01 addresses through B, and one with `acc_mode` 10 addresses through X. Each uses the pointer value from before any post-modify, and maps it through the segment as in R2.
- R4: On an indirect access, `post_mod` 01 adds 1 to the addressed pointer and 10 subtracts 1, both modulo 256. Codes 00 and 11 leave it unchanged. The other pointer never changes.
- R5: `reg_we` with `reg_sel` 00 loads B, 01 loads X, 10 loads the stack pointer, and 11 loads the segment register, each from `reg_wdata`. A load wins over a post-modify, push or pop of the same register in the same cycle.
- R6: `push` issues a write at the current stack pointer in segment 0, whatever the segment register holds. It then decrements the stack pointer modulo 256.
- R7: `pop` (without `push`) increments the stack pointer modulo 256. It issues a read, with `ram_we` low, at the incremented value in segment 0.
- R8: `push` or `pop` takes priority over an `acc_valid` request in the same cycle, and the pointers are then not post-modified. If both strobes are high, only the push is performed.
- R9: When a lower-half offset maps into a segment above 3, `seg_oor` is 1 and `ram_we` is 0 for that access. The address is still output, and any post-modify still takes place. Upper-half offsets and stack accesses never raise `seg_oor`.
- R10: In a cycle with no `acc_valid`, `push` or `pop`, `ram_en`, `ram_we` and `seg_oor` go to 0 and `ram_addr` holds its last value. Without a load, both pointers also keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Request a direct or pointer access |
| acc_mode | input | 2 | 00 direct, 01 via B, 10 via X, 11 direct |
| acc_write | input | 1 | Requested access is a write |
| dir_addr | input | 8 | Offset for direct access |
| post_mod | input | 2 | Pointer post-modify: 01 increment, 10 decrement, 00/11 none |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| reg_we | input | 1 | Register load strobe |
| reg_sel | input | 2 | Load target: 00 B, 01 X, 10 stack pointer, 11 segment |
| reg_wdata | input | 8 | Load value |
| ram_addr | output | 16 | Registered physical RAM address {segment, offset} |
| ram_en | output | 1 | Registered access enable |
| ram_we | output | 1 | Registered write enable |
| seg_oor | output | 1 | Registered out-of-range segment flag |
| b_q | output | 8 | Pointer B |
| x_q | output | 8 | Pointer X |
| sp_q | output | 8 | Stack pointer |
| seg_q | output | 8 | Segment register |

## Verification
The assertions assume that every control input holds a defined 0 or 1 at each rising edge. They also assume that a stack pointer step is only expected when no load of that register arrives in the same cycle, so the push and pop properties are gated on the load strobe. The bench changes all inputs on the falling edge, always with defined values. It drives both directed corner cases and free random mixes that include same-cycle loads and overlapping push and pop. A behavioural model predicts every output on every clock.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT = 2'b00,
    AM_VIA_B  = 2'b01,
    AM_VIA_X  = 2'b10,
    AM_SPARE  = 2'b11
  } am_e;

  typedef enum logic [1:0] {
    PM_KEEP  = 2'b00,
    PM_INC   = 2'b01,
    PM_DEC   = 2'b10,
    PM_KEEP2 = 2'b11
  } pm_e;

  typedef enum logic [1:0] {
    RS_B   = 2'b00,
    RS_X   = 2'b01,
    RS_SP  = 2'b10,
    RS_SEG = 2'b11
  } rsel_e;

  localparam int NUM_PTRS = 2;
endpackage

// File: rtl/sag_ptr_reg.sv
module sag_ptr_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic         touch,
  input  logic [1:0]   pmod,
  output logic [W-1:0] q
);
  import sag_pkg::*;

  logic [W-1:0] stepped;

  always_comb begin
    unique case (pm_e'(pmod))
      PM_INC:  stepped = q + 1'b1;
      PM_DEC:  stepped = q - 1'b1;
      default: stepped = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (ld) begin
      q <= ld_data;
    end else if (touch) begin
      q <= stepped;
    end
  end
endmodule

// File: rtl/sag_stack_ptr.sv
module sag_stack_ptr #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 8'h6F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic         do_push,
  input  logic         do_pop,
  output logic [W-1:0] q,
  output logic [W-1:0] acc_off
);
  logic [W-1:0] up;
  logic [W-1:0] down;

  assign up      = q + 1'b1;
  assign down    = q - 1'b1;
  assign acc_off = do_push ? q : up;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (ld) begin
      q <= ld_data;
    end else if (do_push) begin
      q <= down;
    end else if (do_pop) begin
      q <= up;
    end
  end
endmodule

// File: rtl/sag_seg_map.sv
module sag_seg_map #(
  parameter int OFS_W     = 8,
  parameter int SEG_W     = 8,
  parameter int SEG_LIMIT = 3,
  localparam int PA_W     = SEG_W + OFS_W
) (
  input  logic [OFS_W-1:0] off,
  input  logic [SEG_W-1:0] seg,
  input  logic             force_seg0,
  output logic [PA_W-1:0]  phys,
  output logic             oor
);
  logic             low_half;
  logic [SEG_W-1:0] seg_eff;

  assign low_half = ~off[OFS_W-1];
  assign seg_eff  = (low_half && !force_seg0) ? seg : '0;
  assign phys     = {seg_eff, off};
  assign oor      = (seg_eff > SEG_W'(SEG_LIMIT));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W     = 8,
  parameter int SEG_W     = 8,
  parameter int SEG_LIMIT = 3,
  parameter logic [OFS_W-1:0] SP_RST = 8'h6F,
  localparam int PA_W     = SEG_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [1:0]       acc_mode,
  input  logic             acc_write,
  input  logic [OFS_W-1:0] dir_addr,
  input  logic [1:0]       post_mod,
  input  logic             push,
  input  logic             pop,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [OFS_W-1:0] reg_wdata,
  output logic [PA_W-1:0]  ram_addr,
  output logic             ram_en,
  output logic             ram_we,
  output logic             seg_oor,
  output logic [OFS_W-1:0] b_q,
  output logic [OFS_W-1:0] x_q,
  output logic [OFS_W-1:0] sp_q,
  output logic [SEG_W-1:0] seg_q
);
  import sag_pkg::*;

  logic             stack_op, do_push, do_pop;
  logic             access, wr_req;
  logic [OFS_W-1:0] ptr_q   [NUM_PTRS];
  logic [NUM_PTRS-1:0] ptr_ld, ptr_touch;
  logic [OFS_W-1:0] sp_off;
  logic [OFS_W-1:0] off_sel;
  logic [PA_W-1:0]  phys;
  logic             oor;
  logic             sp_ld, seg_ld;

  assign do_push  = push;
  assign do_pop   = pop & ~push;
  assign stack_op = push | pop;
  assign access   = stack_op | acc_valid;
  assign wr_req   = do_push | (~stack_op & acc_valid & acc_write);
  assign sp_ld    = reg_we && (rsel_e'(reg_sel) == RS_SP);
  assign seg_ld   = reg_we && (rsel_e'(reg_sel) == RS_SEG);

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
    localparam logic [1:0] MY_SEL  = (i == 0) ? RS_B : RS_X;
    localparam logic [1:0] MY_MODE = (i == 0) ? AM_VIA_B : AM_VIA_X;

    assign ptr_ld[i]    = reg_we && (reg_sel == MY_SEL);
    assign ptr_touch[i] = acc_valid && !stack_op && (acc_mode == MY_MODE);

    sag_ptr_reg #(
      .W       (OFS_W),
      .RST_VAL ('0)
    ) u_ptr (
      .clk     (clk),
      .rst     (rst),
      .ld      (ptr_ld[i]),
      .ld_data (reg_wdata),
      .touch   (ptr_touch[i]),
      .pmod    (post_mod),
      .q       (ptr_q[i])
    );
  end

  sag_stack_ptr #(
    .W       (OFS_W),
    .RST_VAL (SP_RST)
  ) u_sp (
    .clk     (clk),
    .rst     (rst),
    .ld      (sp_ld),
    .ld_data (reg_wdata),
    .do_push (do_push),
    .do_pop  (do_pop),
    .q       (sp_q),
    .acc_off (sp_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
    end else if (seg_ld) begin
      seg_q <= SEG_W'(reg_wdata);
    end
  end

  always_comb begin
    if (stack_op) begin
      off_sel = sp_off;
    end else begin
      unique case (am_e'(acc_mode))
        AM_VIA_B: off_sel = ptr_q[0];
        AM_VIA_X: off_sel = ptr_q[1];
        default:  off_sel = dir_addr;
      endcase
    end
  end

  sag_seg_map #(
    .OFS_W     (OFS_W),
    .SEG_W     (SEG_W),
    .SEG_LIMIT (SEG_LIMIT)
  ) u_map (
    .off        (off_sel),
    .seg        (seg_q),
    .force_seg0 (stack_op),
    .phys       (phys),
    .oor        (oor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_en   <= 1'b0;
      ram_we   <= 1'b0;
      seg_oor  <= 1'b0;
    end else begin
      ram_en  <= access;
      ram_we  <= access & wr_req & ~oor;
      seg_oor <= access & oor;
      if (access) begin
        ram_addr <= phys;
      end
    end
  end

  assign b_q = ptr_q[0];
  assign x_q = ptr_q[1];
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int OFS_W     = 8,
  parameter int SEG_W     = 8,
  parameter logic [OFS_W-1:0] SP_RST = 8'h6F,
  localparam int PA_W     = SEG_W + OFS_W
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             push,
  input logic             pop,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic [OFS_W-1:0] reg_wdata,
  input logic [PA_W-1:0]  ram_addr,
  input logic             ram_en,
  input logic             ram_we,
  input logic             seg_oor,
  input logic [OFS_W-1:0] b_q,
  input logic [OFS_W-1:0] x_q,
  input logic [OFS_W-1:0] sp_q,
  input logic [SEG_W-1:0] seg_q
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (sp_q == SP_RST && b_q == '0 && x_q == '0 && seg_q == '0 && !ram_en)); // R1

  AST_UPPER_IN_SEG0: assert property (@(posedge clk) disable iff (rst)
    (ram_en && ram_addr[OFS_W-1]) |-> (ram_addr[PA_W-1:OFS_W] == '0)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'b00) |=> (b_q == $past(reg_wdata))); // R5

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
    (push && !(reg_we && reg_sel == 2'b10)) |=> (sp_q == $past(sp_q) - 1'b1)); // R6

  AST_PUSH_WRITES: assert property (@(posedge clk) disable iff (rst)
    push |=> (ram_we && ram_addr == PA_W'($past(sp_q)))); // R6

  AST_POP_INC: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !(reg_we && reg_sel == 2'b10)) |=> (sp_q == $past(sp_q) + 1'b1 && !ram_we)); // R7

  AST_STACK_NO_OOR: assert property (@(posedge clk) disable iff (rst)
    (push || pop) |=> !seg_oor); // R9

  AST_OOR_NO_WE: assert property (@(posedge clk) disable iff (rst)
    seg_oor |-> !ram_we); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !push && !pop) |=> (!ram_en && !ram_we && $stable(ram_addr))); // R10

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !reg_we) |=> ($stable(b_q) && $stable(x_q))); // R10
endmodule

bind seg_addr_gen sag_checker #(
  .OFS_W  (OFS_W),
  .SEG_W  (SEG_W),
  .SP_RST (SP_RST)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .push      (push),
  .pop       (pop),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .ram_addr  (ram_addr),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .seg_oor   (seg_oor),
  .b_q       (b_q),
  .x_q       (x_q),
  .sp_q      (sp_q),
  .seg_q     (seg_q)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_mode = 2'b00;
  logic        acc_write = 1'b0;
  logic [7:0]  dir_addr = 8'h00;
  logic [1:0]  post_mod = 2'b00;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'b00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [15:0] ram_addr;
  logic        ram_en, ram_we, seg_oor;
  logic [7:0]  b_q, x_q, sp_q, seg_q;

  int n_checks = 0;
  int n_fails  = 0;

  int mb, mx, msp, mseg;
  int e_addr, e_en, e_we, e_oor;

  always #10 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mode(acc_mode),
    .acc_write(acc_write), .dir_addr(dir_addr), .post_mod(post_mod),
    .push(push), .pop(pop), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ram_addr(ram_addr), .ram_en(ram_en),
    .ram_we(ram_we), .seg_oor(seg_oor), .b_q(b_q), .x_q(x_q),
    .sp_q(sp_q), .seg_q(seg_q)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "ram_addr", int'(ram_addr), e_addr);
    chk(tag, "ram_en", int'(ram_en), e_en);
    chk(tag, "ram_we", int'(ram_we), e_we);
    chk(tag, "seg_oor", int'(seg_oor), e_oor);
    chk(tag, "b_q", int'(b_q), mb);
    chk(tag, "x_q", int'(x_q), mx);
    chk(tag, "sp_q", int'(sp_q), msp);
    chk(tag, "seg_q", int'(seg_q), mseg);
  endtask

  function automatic int stepv(int v, int pm);
    if (pm == 1) return (v + 1) & 255;
    if (pm == 2) return (v + 255) & 255;
    return v;
  endfunction

  // one request cycle: drive at falling edge, predict, compare at next falling edge
  task automatic step(bit v, int md, bit wr, int da, int pm, bit pu, bit po,
                      bit rwe, int rs, int rwd, string tag);
    bit stk, acc, oor;
    int off, sgu, nb, nx, nsp, nseg;
    acc_valid = v; acc_mode = md[1:0]; acc_write = wr; dir_addr = da[7:0];
    post_mod = pm[1:0]; push = pu; pop = po; reg_we = rwe;
    reg_sel = rs[1:0]; reg_wdata = rwd[7:0];
    stk = pu | po;
    acc = stk | v;
    if (stk) off = pu ? msp : ((msp + 1) & 255);
    else if (v && md == 1) off = mb;
    else if (v && md == 2) off = mx;
    else off = da;
    sgu = (!stk && off < 128) ? mseg : 0;
    oor = acc && (sgu > 3);
    e_en = int'(acc);
    e_we = int'(acc && !oor && (pu || (!stk && wr)));
    e_oor = int'(oor);
    if (acc) e_addr = sgu * 256 + off;
    nb = mb; nx = mx; nsp = msp; nseg = mseg;
    if (rwe && rs == 0) nb = rwd;
    else if (v && !stk && md == 1) nb = stepv(mb, pm);
    if (rwe && rs == 1) nx = rwd;
    else if (v && !stk && md == 2) nx = stepv(mx, pm);
    if (rwe && rs == 2) nsp = rwd;
    else if (pu) nsp = (msp + 255) & 255;
    else if (po) nsp = (msp + 1) & 255;
    if (rwe && rs == 3) nseg = rwd;
    @(posedge clk);
    @(negedge clk);
    mb = nb; mx = nx; msp = nsp; mseg = nseg;
    check_all(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic load(int rs, int val, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, rs, val, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    mb = 0; mx = 0; msp = 8'h6F; mseg = 0;
    e_addr = 0; e_en = 0; e_we = 0; e_oor = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;

    // R2 direct, segment 0, both halves
    step(1, 0, 1, 8'h12, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 3, 0, 8'h9A, 0, 0, 0, 0, 0, 0, "R2");
    idle("R10");
    // R2 with segment 2
    load(3, 2, "R5");
    step(1, 0, 1, 8'h7F, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 1, 8'h80, 0, 0, 0, 0, 0, 0, "R2");
    // R3 / R4 pointer accesses
    load(0, 8'h10, "R5");
    step(1, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 3, 0, 0, 0, 0, 0, "R4");
    step(1, 2, 0, 0, 2, 0, 0, 0, 0, 0, "R4");
    load(0, 8'hFF, "R5");
    step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    step(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R5 load beats post-modify
    step(1, 1, 0, 0, 1, 0, 0, 1, 0, 8'h55, "R5");
    step(1, 2, 0, 0, 2, 0, 0, 1, 1, 8'h44, "R5");
    // R6 / R7 stack with segment 2 active
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
    // R8 stack beats pointer request, push beats pop
    step(1, 1, 1, 0, 1, 1, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R8");
    step(1, 2, 0, 0, 2, 0, 1, 0, 0, 0, "R8");
    // R5 SP load beats push
    step(0, 0, 0, 0, 0, 1, 0, 1, 2, 8'h00, "R5");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
    // R9 segment limits
    load(3, 3, "R9");
    step(1, 0, 1, 8'h05, 0, 0, 0, 0, 0, 0, "R9");
    load(3, 4, "R9");
    step(1, 0, 1, 8'h05, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 0, 1, 8'hC0, 0, 0, 0, 0, 0, 0, "R9");
    load(0, 8'h20, "R9");
    step(1, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
    idle("R10");
    step(0, 1, 1, 8'h33, 1, 0, 0, 0, 0, 0, "R10");

    // random mix over all inputs
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 255), $urandom_range(0, 3),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 3) == 0), $urandom_range(0, 3),
           ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : $urandom_range(0, 255),
           "R8");
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule